// File: doc/BRIEF.md
# Load/Store Port Memory Adapter

This block is one load/store port placed in front of a small private memory whose words are 64 bits wide. A requester asks for a load or a store of 1, 2, 4 or 8 bytes at a byte address. The port takes the address and answers with a one-cycle address-accepted pulse and a busy flag. It then turns the low address bits and the length into byte-lane enables and does the work. A store moves its data up into the addressed lanes and leaves the other lanes alone. A load picks the addressed lanes out of the word and returns them right-justified and zero-filled, together with a one-cycle valid flag.

The exchange has a fixed shape. While busy is low, the requester raises its load or store flag, drives the length, and holds the address with its valid flag. It waits for the accepted pulse. On a store it then presents the data with a strobe for exactly one clock. On a load it waits for the load-valid flag. When busy falls, the requester drops its flags. The port does not start another operation until it has seen the flags drop. Accesses that cross an 8-byte boundary are not supported.

Top module: `lsport_mem`

## Requirements
- R1: After reset, `busy_o`, `addr_ack_o` and `ld_vld_o` are 0 and every memory word reads back as zero.
- R2: A request is taken only in the idle state. It needs `addr_vld_i` high together with `ld_req_i` or `st_req_i`, and it is taken on the rising edge where these hold. `addr_ack_o` is then high for exactly the one following cycle. If `addr_vld_i` is low, nothing is taken.
- R3: `busy_o` is high from the cycle after a request is taken until the operation completes. It is low in the cycle after a store strobe is taken, and in the cycle after load data is returned.
- R4: Store data is captured on the single cycle in which `st_vld_i` is high. That cycle may be the acknowledge cycle or any later cycle while the port is still busy.
- R5: For a load, `ld_vld_o` is high for exactly the one cycle after the acknowledge cycle, and `ld_data_o` holds the result in that cycle.
- R6: `len_i` carries the byte count as a plain binary number: 1, 2, 4 or 8. Lane k of the 64-bit word holds bits [8k+7:8k]. The enabled lanes are the `len_i` lanes starting at lane `addr_i[2:0]`. For example, a 2-byte access at offset 6 uses lanes 6 and 7.
- R7: A store changes only the enabled lanes. All other lanes of the word keep their contents, and store data bits above `8*len_i` are ignored.
- R8: Load data is right-justified: the byte from lane `addr_i[2:0]` appears at bits [7:0]. Bits at and above `8*len_i` are zero.
- R9: Byte order is little-endian. A 2-byte store of 0xBEEF at address 4, then a 2-byte store of 0xF00F at address 6, reads back as 0xF00FBEEF from a 4-byte load at address 4.
- R10: After completion, while any of `addr_vld_i`, `ld_req_i` or `st_req_i` stays high, no new request is taken: `addr_ack_o` and `busy_o` stay 0.
- R11: The word index is `addr_i[3+log2(WORDS)-1:3]`. Address bits above the index are ignored, so addresses that differ only in those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_req_i | input | 1 | Load request flag |
| st_req_i | input | 1 | Store request flag |
| len_i | input | 4 | Access length in bytes (1, 2, 4, 8) |
| addr_i | input | ADDR_W | Byte address |
| addr_vld_i | input | 1 | Address valid |
| st_data_i | input | 64 | Store data, right-justified |
| st_vld_i | input | 1 | Store data strobe, one cycle |
| addr_ack_o | output | 1 | Address accepted, one-cycle pulse |
| busy_o | output | 1 | Operation in progress |
| ld_data_o | output | 64 | Load data, right-justified and zero-extended |
| ld_vld_o | output | 1 | Load data valid, one-cycle pulse |

## Verification
The bench builds the port with WORDS=4, which keeps the memory small enough for a full sweep. It stores to and loads from every aligned offset for every length in every word, and it reads each whole word back after every store. This checks lane placement, lane preservation and zero-extension against a byte-level model. The small index field also brings address aliasing within reach: setting address bits above bit 4 must hit the same four words. The sweep alternates between strobing store data in the acknowledge cycle and strobing it a few cycles later.

// File: rtl/lsport_pkg.sv
package lsport_pkg;
  localparam int LANES  = 8;
  localparam int DATA_W = LANES * 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [2:0] {
    S_IDLE, S_ACC, S_SDAT, S_LRET, S_DONE
  } lsp_state_e;

  // lanes enabled by a length (in bytes) starting at a lane offset
  function automatic logic [LANES-1:0] lane_mask(input logic [OFF_W-1:0] off,
                                                 input logic [3:0] nbytes);
    logic [2*LANES-1:0] run;
    run = ((2*LANES)'(1) << nbytes) - (2*LANES)'(1);
    run = run << off;
    return run[LANES-1:0];
  endfunction

  // widen a lane mask to a bit mask
  function automatic logic [DATA_W-1:0] lanes_to_bits(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  // bit mask covering the low nbytes bytes
  function automatic logic [DATA_W-1:0] keep_low(input logic [3:0] nbytes);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = (i < int'(nbytes)) ? 8'hFF : 8'h00;
    return m;
  endfunction
endpackage

// File: rtl/lsp_lanes.sv
module lsp_lanes
  import lsport_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  logic [3:0]        nbytes_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wr_word_o,
  output logic [DATA_W-1:0] ld_word_o
);
  logic [DATA_W-1:0] st_shift;
  logic [DATA_W-1:0] rd_shift;

  assign be_o     = lane_mask(off_i, nbytes_i);
  assign st_shift = st_data_i << {off_i, 3'b000};
  assign rd_shift = rd_word_i >> {off_i, 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_word_o[g*8 +: 8] = be_o[g] ? st_shift[g*8 +: 8] : rd_word_i[g*8 +: 8];
  end

  assign ld_word_o = rd_shift & keep_low(nbytes_i);
endmodule

// File: rtl/lsp_mem.sv
module lsp_mem
  import lsport_pkg::*;
#(
  parameter int WORDS = 16,
  localparam int IW   = $clog2(WORDS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     idx_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_word_i,
  output logic [DATA_W-1:0] rd_word_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[idx_i] <= wr_word_i;
    end
  end

  assign rd_word_o = mem_q[idx_i];
endmodule

// File: rtl/lsp_ctrl.sv
module lsp_ctrl
  import lsport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld_req_i,
  input  logic st_req_i,
  input  logic addr_vld_i,
  input  logic st_vld_i,
  output logic accept_o,
  output logic wr_en_o,
  output logic ld_cap_o,
  output logic addr_ack_o,
  output logic busy_o,
  output logic ld_vld_o
);
  lsp_state_e state_q, state_d;
  logic       is_st_q;
  logic       any_req;

  assign any_req  = ld_req_i | st_req_i;
  assign accept_o = (state_q == S_IDLE) && addr_vld_i && any_req;
  assign wr_en_o  = is_st_q && st_vld_i && (state_q == S_ACC || state_q == S_SDAT);
  assign ld_cap_o = !is_st_q && (state_q == S_ACC);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept_o) state_d = S_ACC;
      S_ACC:  if (!is_st_q)     state_d = S_LRET;
              else if (st_vld_i) state_d = S_DONE;
              else               state_d = S_SDAT;
      S_SDAT: if (st_vld_i) state_d = S_DONE;
      S_LRET: state_d = S_DONE;
      S_DONE: if (!addr_vld_i && !any_req) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      is_st_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) is_st_q <= st_req_i;
    end
  end

  assign addr_ack_o = (state_q == S_ACC);
  assign busy_o     = (state_q == S_ACC) || (state_q == S_SDAT) || (state_q == S_LRET);
  assign ld_vld_o   = (state_q == S_LRET);
endmodule

// File: rtl/lsport_mem.sv
module lsport_mem
  import lsport_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int WORDS  = 16,
  localparam int IW    = $clog2(WORDS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req_i,
  input  logic              st_req_i,
  input  logic [3:0]        len_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_vld_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              st_vld_i,
  output logic              addr_ack_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_vld_o
);
  logic              accept, wr_en, ld_cap;
  logic [OFF_W-1:0]  off_q;
  logic [IW-1:0]     idx_q;
  logic [3:0]        len_q;
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] rd_word, wr_word, ld_word;
  logic [DATA_W-1:0] ld_data_q;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^addr_i[ADDR_W-1:OFF_W+IW];

  lsp_ctrl u_ctrl (
    .clk, .rst_n, .ld_req_i, .st_req_i, .addr_vld_i, .st_vld_i,
    .accept_o(accept), .wr_en_o(wr_en), .ld_cap_o(ld_cap),
    .addr_ack_o, .busy_o, .ld_vld_o
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q     <= '0;
      idx_q     <= '0;
      len_q     <= '0;
      ld_data_q <= '0;
    end else begin
      if (accept) begin
        off_q <= addr_i[OFF_W-1:0];
        idx_q <= addr_i[OFF_W +: IW];
        len_q <= len_i;
      end
      if (ld_cap) ld_data_q <= ld_word;
    end
  end

  lsp_lanes u_lanes (
    .off_i(off_q), .nbytes_i(len_q), .st_data_i,
    .rd_word_i(rd_word), .be_o(be), .wr_word_o(wr_word), .ld_word_o(ld_word)
  );

  lsp_mem #(.WORDS(WORDS)) u_mem (
    .clk, .rst_n, .idx_i(idx_q), .wr_en_i(wr_en),
    .wr_word_i(wr_word), .rd_word_o(rd_word)
  );

  assign ld_data_o = ld_data_q;
endmodule

// File: rtl/lsport_mem_chk.sv
module lsport_mem_chk
  import lsport_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ld_req_i,
  input logic              st_req_i,
  input logic              addr_vld_i,
  input logic              st_vld_i,
  input logic              addr_ack_o,
  input logic              busy_o,
  input logic              ld_vld_o,
  input logic [DATA_W-1:0] ld_data_o,
  input logic              wr_en,
  input logic [3:0]        len_q,
  input logic [LANES-1:0]  be,
  input logic [DATA_W-1:0] rd_word,
  input logic [DATA_W-1:0] wr_word
);
  AST_ACK_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) addr_ack_o |=> !addr_ack_o); // R2
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(addr_ack_o) |-> $past(addr_vld_i && (ld_req_i || st_req_i) && !busy_o)); // R2
  AST_ACK_BUSY:      assert property (@(posedge clk) disable iff (!rst_n) addr_ack_o |-> busy_o); // R3
  AST_LDV_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) ld_vld_o |-> $past(addr_ack_o) && !addr_ack_o); // R5
  AST_WR_IN_WINDOW:  assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> busy_o && st_vld_i); // R4
  AST_WR_DONE:       assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !busy_o); // R3
  AST_KEEP_LANES:    assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> ((wr_word ^ rd_word) & ~lanes_to_bits(be)) == '0); // R7
  AST_LD_ZEROEXT:    assert property (@(posedge clk) disable iff (!rst_n) (ld_vld_o && len_q < 4'd8) |-> (ld_data_o >> {len_q, 3'b000}) == '0); // R8
endmodule

bind lsport_mem lsport_mem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_req_i(ld_req_i), .st_req_i(st_req_i),
  .addr_vld_i(addr_vld_i), .st_vld_i(st_vld_i), .addr_ack_o(addr_ack_o),
  .busy_o(busy_o), .ld_vld_o(ld_vld_o), .ld_data_o(ld_data_o),
  .wr_en(wr_en), .len_q(len_q), .be(be), .rd_word(rd_word), .wr_word(wr_word)
);

// File: tb/lsport_mem_tb.sv
module lsport_mem_tb;
  localparam int ADDR_W = 48;
  localparam int WORDS  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ld_req_i = 0, st_req_i = 0, addr_vld_i = 0, st_vld_i = 0;
  logic [3:0]        len_i = 0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [63:0]       st_data_i = '0;
  logic              addr_ack_o, busy_o, ld_vld_o;
  logic [63:0]       ld_data_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic [7:0] model [WORDS*8];

  always #2 clk = ~clk;

  lsport_mem #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_dut (
    .clk, .rst_n, .ld_req_i, .st_req_i, .len_i, .addr_i, .addr_vld_i,
    .st_data_i, .st_vld_i, .addr_ack_o, .busy_o, .ld_data_o, .ld_vld_o
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int widx(input logic [ADDR_W-1:0] a);
    return int'((a >> 3) % WORDS);
  endfunction

  function automatic logic [63:0] expect_ld(input logic [ADDR_W-1:0] a, input int len);
    logic [63:0] v = '0;
    for (int k = 0; k < len; k++) v[k*8 +: 8] = model[widx(a)*8 + int'(a[2:0]) + k];
    return v;
  endfunction

  task automatic do_store(input logic [ADDR_W-1:0] a, input int len,
                          input logic [63:0] d, input int delay);
    st_req_i = 1; len_i = 4'(len); addr_i = a; addr_vld_i = 1;
    @(negedge clk);
    check("R2 ack", {63'b0, addr_ack_o}, 64'd1);
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      check("R4 busy while waiting", {63'b0, busy_o}, 64'd1);
    end
    st_data_i = d; st_vld_i = 1;
    @(negedge clk);
    st_vld_i = 0; st_data_i = '0;
    check("R3 done after strobe", {63'b0, busy_o}, 64'd0);
    st_req_i = 0; addr_vld_i = 0;
    @(negedge clk);
    for (int k = 0; k < len; k++) model[widx(a)*8 + int'(a[2:0]) + k] = d[k*8 +: 8];
  endtask

  task automatic do_load(input logic [ADDR_W-1:0] a, input int len,
                         input string req, input int hold);
    logic [63:0] e;
    e = expect_ld(a, len);
    ld_req_i = 1; len_i = 4'(len); addr_i = a; addr_vld_i = 1;
    @(negedge clk);
    check("R2 ack", {62'b0, addr_ack_o, ld_vld_o}, 64'd2);
    @(negedge clk);
    check("R5 ld_vld", {62'b0, ld_vld_o, addr_ack_o}, 64'd2);
    check(req, ld_data_o, e);
    @(negedge clk);
    check("R3 idle after load", {63'b0, busy_o}, 64'd0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R10 held flags ignored", {62'b0, addr_ack_o, busy_o}, 64'd0);
    end
    ld_req_i = 0; addr_vld_i = 0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS*8; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {61'b0, busy_o, addr_ack_o, ld_vld_o}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle after reset", {61'b0, busy_o, addr_ack_o, ld_vld_o}, 64'd0);
    for (int w = 0; w < WORDS; w++) do_load(ADDR_W'(w*8), 8, "R1 memory cleared", 0);

    // request without address valid is ignored
    ld_req_i = 1; addr_i = 48'h8; len_i = 4'd8;
    repeat (3) begin
      @(negedge clk);
      check("R2 no ack without addr valid", {62'b0, addr_ack_o, busy_o}, 64'd0);
    end
    ld_req_i = 0;
    @(negedge clk);

    // little-endian example
    do_store(48'h4, 2, 64'hBEEF, 0);
    do_store(48'h6, 2, 64'hF00F, 1);
    do_load(48'h4, 2, "R9 low half", 0);
    do_load(48'h6, 2, "R9 high half", 0);
    do_load(48'h4, 4, "R9 joined", 2);
    check("R9 literal", expect_ld(48'h4, 4), 64'hF00FBEEF);

    // sweep: every length, word and aligned offset
    for (int li = 0; li < 4; li++) begin
      int len = 1 << li;
      for (int w = 0; w < WORDS; w++) begin
        for (int off = 0; off < 8; off += len) begin
          logic [ADDR_W-1:0] a = ADDR_W'(w*8 + off);
          logic [63:0] d = 64'h0123_4567_89AB_CDEF ^ (64'(w) * 64'h1111_0000_0101)
                           ^ (64'(off) * 64'h0101_0101) ^ (64'(len) << 56);
          do_store(a, len, d, (off + w) % 3);
          do_load(a, len, "R6 R8 load of stored lanes", 0);
          do_load(ADDR_W'(w*8), 8, "R7 whole word preserved", 0);
        end
      end
    end

    // aliasing through upper address bits
    do_store(48'hABC0_0000_0010, 4, 64'hDEAD_BEEF_CAFE_F00D, 0);
    do_load(48'h0000_0000_0010, 8, "R11 alias store", 0);
    do_load(48'h7000_0000_0030, 4, "R11 alias load", 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule